// File: doc/BRIEF.md
# Daisy-Chain Trigger Primitive Merge Node

This block is one stage of a chain of trigger boards. Each board receives 64-bit trigger primitives from the board before it, adds the primitives it produces itself, and passes the combined stream to the next board. On both links a primitive travels as four consecutive 16-bit words, each marked by a valid strobe. Incoming words are rebuilt into whole primitives and held in a queue. Local primitives wait in a separate four-entry queue. An arbiter then sends whole primitives downstream, most significant word first, and never interleaves two primitives.

A mode input selects between two behaviours. In pass-through mode every primitive leaves the node unchanged. In combining mode, a local primitive that carries the same timestamp as the upstream primitive being sent is folded into it: the two hit masks are ORed and one primitive goes out instead of two, which lowers the load on the downstream link. The node also handles broken or excess traffic. An upstream primitive that is cut short is discarded and counted. A push into a full queue drops that whole primitive and sets a sticky flag.

Top module: `chain_merge_node`

## Requirements
- R1: A primitive is 64 bits: [63:48] timestamp, [47:32] source/type, [31:0] hit mask. On both links it is carried as exactly 4 consecutive valid words, bits [63:48] first and bits [15:0] last. `dn_valid` is high only in whole runs of 4 cycles.
- R2: On an idle node, the first word of an upstream primitive appears on `dn_data` with `dn_valid` high right after the rising edge that follows the edge sampling the primitive's 4th upstream word.
- R3: With `merge_en`=0, every upstream and local primitive is forwarded bit for bit unchanged, with no interleaving of words from different primitives.
- R4: At a primitive boundary, when both an upstream and a local primitive are waiting, the upstream one is sent first.
- R5: A local primitive presented on `loc_prim` with `loc_valid` for one cycle is forwarded when no upstream traffic is waiting.
- R6: With `merge_en`=1, when the arbiter takes an upstream primitive and the oldest waiting local primitive has the same timestamp, exactly one primitive is sent. It has the upstream bits [63:32] and the OR of both hit masks in [31:0].
- R7: With `merge_en`=1 and different timestamps, both primitives are sent separately and unchanged, upstream first.
- R8: If `up_valid` drops after 1 to 3 words of a primitive, those words are discarded and `frag_count` rises by one, saturating. Nothing is sent for the fragment, and the next complete primitive is forwarded intact.
- R9: Each queue holds 4 primitives. A push while a queue holds 4 is dropped whole, even if a primitive leaves in the same cycle, and it sets `ovf_flag`, which stays set until reset.
- R10: A low `rst_n` sampled on a rising edge empties both queues, stops the output, and clears `frag_count` and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| merge_en | input | 1 | 1 = combining mode, 0 = pass-through mode |
| up_data | input | 16 | Upstream link word |
| up_valid | input | 1 | Upstream word valid |
| loc_prim | input | 64 | Locally generated primitive |
| loc_valid | input | 1 | Push `loc_prim` into the local queue |
| dn_data | output | 16 | Downstream link word |
| dn_valid | output | 1 | Downstream word valid |
| frag_count | output | 8 | Saturating count of discarded incomplete primitives |
| ovf_flag | output | 1 | Sticky queue overflow flag |

## Verification
An upstream primitive goes through two registers on its way out: the queue write on the edge that samples its 4th word, and the arbiter load on the next edge. The bench therefore checks `dn_valid` low at the first falling edge after the last word and high, with the top word, at the falling edge after that. The table cases and the overflow case compare complete primitives, rebuilt by a monitor at falling edges, after a fixed wait of several primitive times. The overflow expectation follows the arbiter's 4-cycle slot: the 6th and 8th of eight back-to-back local pushes meet a full queue. The fragment and reset checks read `frag_count` and `ovf_flag` a few cycles after the triggering edge, and then confirm that nothing further leaves the node.

// File: rtl/chain_pkg.sv
// Package: shared constants and the primitive layout for the chain merge node.
// Assumes a primitive is an integral number of link beats.
package chain_pkg;
    localparam int BEAT_W     = 16;
    localparam int BEATS      = 4;
    localparam int PRIM_W     = BEAT_W * BEATS;
    localparam int BEAT_CNT_W = $clog2(BEATS);
    localparam logic [BEAT_CNT_W-1:0] LAST_BEAT = BEAT_CNT_W'(BEATS - 1);

    typedef struct packed {
        logic [15:0] stamp;
        logic [15:0] kind;
        logic [31:0] hits;
    } prim_t;
endpackage

// File: rtl/chain_rx_assembler.sv
// Rebuilds 64-bit primitives from upstream beats, first beat most significant.
// Assumes a primitive occupies BEATS back-to-back valid cycles; a gap before
// the last beat discards the partial primitive and pulses frag_evt.
module chain_rx_assembler
    import chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              in_valid,
    output prim_t             prim,
    output logic              prim_done,
    output logic              frag_evt
);
    localparam int ACC_W = PRIM_W - BEAT_W;

    logic [BEAT_CNT_W-1:0] beat;
    logic [ACC_W-1:0]      acc;

    // Beat counter and shift accumulator for the words of the current primitive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
            acc  <= '0;
        end else if (in_valid) begin
            acc  <= {acc[ACC_W-BEAT_W-1:0], in_data};
            beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
        end else begin
            beat <= '0;
        end
    end

    // Completion and fragment decode from the current beat position.
    always_comb begin
        prim      = prim_t'({acc, in_data});
        prim_done = in_valid && (beat == LAST_BEAT);
        frag_evt  = !in_valid && (beat != '0);
    end
endmodule

// File: rtl/chain_prim_fifo.sv
// Whole-primitive FIFO. Each entry is one 64-bit primitive, so a drop always
// removes a complete primitive. A push arriving while full is refused even if
// a pop happens in the same cycle; drop pulses for that push.
// Assumes DEPTH is a power of two, at least 2.
module chain_prim_fifo
    import chain_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  prim_t push_data,
    input  logic  pop,
    output prim_t head,
    output logic  not_empty,
    output logic  drop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    prim_t             mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic              do_push;
    logic              do_pop;

    // Occupancy decode and accepted push/pop strobes.
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        not_empty = (count != '0);
        do_push   = push && !full;
        do_pop    = pop && not_empty;
        drop      = push && full;
        head      = mem[rptr];
    end

    // Storage write; contents need no reset because count guards reads.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/chain_tx_arbiter.sv
// Picks the next whole primitive at each 4-beat boundary (upstream first),
// optionally folds a same-timestamp local primitive into it, and shifts it
// out most significant beat first. Output is registered.
// Assumes queue heads are valid whenever their not-empty flags are set.
module chain_tx_arbiter
    import chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              merge_en,
    input  prim_t             up_head,
    input  logic              up_ne,
    input  prim_t             loc_head,
    input  logic              loc_ne,
    output logic              up_pop,
    output logic              loc_pop,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_valid
);
    logic                  busy;
    logic [BEAT_CNT_W-1:0] cnt;
    logic [PRIM_W-1:0]     shreg;
    logic                  boundary;
    logic                  match;
    prim_t                 up_sel;

    // Boundary detection, timestamp match and source selection.
    always_comb begin
        boundary = !busy || (cnt == LAST_BEAT);
        match    = merge_en && up_ne && loc_ne && (up_head.stamp == loc_head.stamp);
        up_pop   = boundary && up_ne;
        loc_pop  = boundary && loc_ne && (!up_ne || match);
        up_sel   = up_head;
        if (match) begin
            up_sel.hits = up_head.hits | loc_head.hits;
        end
        out_data  = shreg[PRIM_W-1 -: BEAT_W];
        out_valid = busy;
    end

    // Load a new primitive at a boundary, otherwise shift out the next beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else if (boundary) begin
            cnt <= '0;
            if (up_ne) begin
                busy  <= 1'b1;
                shreg <= up_sel;
            end else if (loc_ne) begin
                busy  <= 1'b1;
                shreg <= loc_head;
            end else begin
                busy  <= 1'b0;
            end
        end else begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[PRIM_W-BEAT_W-1:0], {BEAT_W{1'b0}}};
        end
    end
endmodule

// File: rtl/chain_merge_node.sv
// Top of the daisy-chain merge node: upstream assembler, upstream and local
// primitive queues, boundary arbiter/serializer, fragment counter and sticky
// overflow flag. Assumes one clock for both links and a synchronous reset.
module chain_merge_node
    import chain_pkg::*;
#(
    parameter int UP_DEPTH  = 4,
    parameter int LOC_DEPTH = 4,
    parameter int FRAG_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              merge_en,
    input  logic [BEAT_W-1:0] up_data,
    input  logic              up_valid,
    input  logic [PRIM_W-1:0] loc_prim,
    input  logic              loc_valid,
    output logic [BEAT_W-1:0] dn_data,
    output logic              dn_valid,
    output logic [FRAG_W-1:0] frag_count,
    output logic              ovf_flag
);
    prim_t rx_prim;
    logic  rx_done;
    logic  frag_evt;
    prim_t up_head;
    prim_t loc_head;
    logic  up_ne;
    logic  loc_ne;
    logic  up_pop;
    logic  loc_pop;
    logic  up_drop;
    logic  loc_drop;

    chain_rx_assembler u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (up_data),
        .in_valid  (up_valid),
        .prim      (rx_prim),
        .prim_done (rx_done),
        .frag_evt  (frag_evt)
    );

    chain_prim_fifo #(.DEPTH(UP_DEPTH)) u_up_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_done),
        .push_data (rx_prim),
        .pop       (up_pop),
        .head      (up_head),
        .not_empty (up_ne),
        .drop      (up_drop)
    );

    chain_prim_fifo #(.DEPTH(LOC_DEPTH)) u_loc_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (loc_valid),
        .push_data (prim_t'(loc_prim)),
        .pop       (loc_pop),
        .head      (loc_head),
        .not_empty (loc_ne),
        .drop      (loc_drop)
    );

    chain_tx_arbiter u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .merge_en  (merge_en),
        .up_head   (up_head),
        .up_ne     (up_ne),
        .loc_head  (loc_head),
        .loc_ne    (loc_ne),
        .up_pop    (up_pop),
        .loc_pop   (loc_pop),
        .out_data  (dn_data),
        .out_valid (dn_valid)
    );

    // Saturating count of discarded fragments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frag_count <= '0;
        end else if (frag_evt && (frag_count != '1)) begin
            frag_count <= frag_count + 1'b1;
        end
    end

    // Sticky flag for any refused queue push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (up_drop || loc_drop) begin
            ovf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/chain_merge_node_chk.sv
// Checker for chain_merge_node, attached by bind. Watches output framing,
// fragment counting, overflow stickiness and reset clearing.
module chain_merge_node_chk
    import chain_pkg::*;
#(
    parameter int FRAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dn_valid,
    input logic [FRAG_W-1:0] frag_count,
    input logic              ovf_flag,
    input logic              frag_evt
);
    logic [BEAT_CNT_W-1:0] ocnt;

    // Position of the output within its 4-beat run.
    always_ff @(posedge clk) begin
        if (!rst_n) ocnt <= '0;
        else if (dn_valid) ocnt <= ocnt + 1'b1;
    end

    AST_DN_WHOLE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_valid |-> (ocnt == '0)); // R1

    AST_FRAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_evt && (frag_count != '1)) |=> (frag_count - $past(frag_count) == FRAG_W'(1))); // R8

    AST_FRAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frag_evt |=> $stable(frag_count)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!dn_valid && (frag_count == '0) && !ovf_flag)); // R10
endmodule

bind chain_merge_node chain_merge_node_chk #(.FRAG_W(FRAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dn_valid   (dn_valid),
    .frag_count (frag_count),
    .ovf_flag   (ovf_flag),
    .frag_evt   (frag_evt)
);

// File: tb/chain_merge_node_bench.sv
// Bench: table of merge/pass-through cases, then directed latency, local-only,
// fragment, overflow and reset tests. Outputs are sampled on falling edges.
module chain_merge_node_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        merge_en = 1'b0;
    logic [15:0] up_data = '0;
    logic        up_valid = 1'b0;
    logic [63:0] loc_prim = '0;
    logic        loc_valid = 1'b0;
    logic [15:0] dn_data;
    logic        dn_valid;
    logic [7:0]  frag_count;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    chain_merge_node u_chain_merge_node (
        .clk(clk), .rst_n(rst_n), .merge_en(merge_en),
        .up_data(up_data), .up_valid(up_valid),
        .loc_prim(loc_prim), .loc_valid(loc_valid),
        .dn_data(dn_data), .dn_valid(dn_valid),
        .frag_count(frag_count), .ovf_flag(ovf_flag)
    );

    // Output monitor: rebuilds primitives into a 16-entry ring.
    logic [63:0] cap [16];
    logic [63:0] macc = '0;
    int          mbeat = 0;
    int          mon_total = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mbeat = 0;
        end else if (dn_valid) begin
            macc = {macc[47:0], dn_data};
            if (mbeat == 3) begin
                cap[mon_total & 15] = macc;
                mon_total = mon_total + 1;
                mbeat = 0;
            end else begin
                mbeat = mbeat + 1;
            end
        end else begin
            mbeat = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_up(input logic [63:0] p, input bit with_loc, input logic [63:0] lp);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            up_valid = 1'b1;
            up_data  = p[63 - 16*i -: 16];
            if (i == 3 && with_loc) begin
                loc_valid = 1'b1;
                loc_prim  = lp;
            end
        end
        @(negedge clk);
        up_valid  = 1'b0;
        loc_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        merge;
        logic [63:0] up;
        logic [63:0] loc;
        logic [1:0]  nexp;
        logic [63:0] e0;
        logic [63:0] e1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 64'h1111_0A01_0000_00F0, 64'h1111_0B02_0000_000F, 2'd2,
          64'h1111_0A01_0000_00F0, 64'h1111_0B02_0000_000F},
        '{1'b1, 64'h2222_0A01_8000_0001, 64'h2222_0B02_0000_0100, 2'd1,
          64'h2222_0A01_8000_0101, 64'h0},
        '{1'b1, 64'h3333_0A01_0000_1000, 64'h3334_0B02_0000_2000, 2'd2,
          64'h3333_0A01_0000_1000, 64'h3334_0B02_0000_2000},
        '{1'b1, 64'h4444_0C03_FF00_FF00, 64'h4444_0D04_0F0F_0F0F, 2'd1,
          64'h4444_0C03_FF0F_FF0F, 64'h0},
        '{1'b0, 64'h5555_0A01_0000_0001, 64'h5555_0B02_0000_0002, 2'd2,
          64'h5555_0A01_0000_0001, 64'h5555_0B02_0000_0002}
    };

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        chk(!dn_valid, "R10 reset dn_valid", 64'(dn_valid), 64'h0);
        chk(frag_count == 0, "R10 reset frag_count", 64'(frag_count), 64'h0);
        chk(!ovf_flag, "R10 reset ovf_flag", 64'(ovf_flag), 64'h0);
        rst_n = 1'b1;
        idle(2);

        // Table: R3/R4 pass-through order, R6 merge, R7 distinct timestamps.
        for (int v = 0; v < 5; v++) begin
            merge_en = VECS[v].merge;
            base = mon_total;
            send_up(VECS[v].up, 1'b1, VECS[v].loc);
            idle(16);
            chk(mon_total - base == int'(VECS[v].nexp), "R3/R6/R7 primitive count",
                64'(mon_total - base), 64'(VECS[v].nexp));
            chk(cap[base & 15] == VECS[v].e0, "R4/R6 first primitive",
                cap[base & 15], VECS[v].e0);
            if (VECS[v].nexp == 2)
                chk(cap[(base + 1) & 15] == VECS[v].e1, "R3/R7 second primitive",
                    cap[(base + 1) & 15], VECS[v].e1);
        end

        // R2 latency and R1 word order.
        merge_en = 1'b0;
        base = mon_total;
        send_up(64'hABCD_1234_5678_9ABC, 1'b0, 64'h0);
        chk(!dn_valid, "R2 not yet valid", 64'(dn_valid), 64'h0);
        @(negedge clk);
        chk(dn_valid && dn_data == 16'hABCD, "R2 first word due", 64'({dn_valid, dn_data}), 64'h1ABCD);
        idle(8);
        chk(cap[base & 15] == 64'hABCD_1234_5678_9ABC, "R1 word order",
            cap[base & 15], 64'hABCD_1234_5678_9ABC);

        // R5 local-only forwarding.
        base = mon_total;
        @(negedge clk);
        loc_valid = 1'b1;
        loc_prim  = 64'h7777_0E05_DEAD_BEEF;
        @(negedge clk);
        loc_valid = 1'b0;
        idle(10);
        chk(mon_total - base == 1, "R5 local count", 64'(mon_total - base), 64'h1);
        chk(cap[base & 15] == 64'h7777_0E05_DEAD_BEEF, "R5 local value",
            cap[base & 15], 64'h7777_0E05_DEAD_BEEF);

        // R8 fragment discard.
        base = mon_total;
        @(negedge clk); up_valid = 1'b1; up_data = 16'h9999;
        @(negedge clk); up_data = 16'h8888;
        @(negedge clk); up_valid = 1'b0;
        idle(8);
        chk(frag_count == 1, "R8 frag_count", 64'(frag_count), 64'h1);
        chk(mon_total == base, "R8 nothing sent", 64'(mon_total - base), 64'h0);
        send_up(64'h6666_0F06_0000_0042, 1'b0, 64'h0);
        idle(10);
        chk(mon_total - base == 1 && cap[base & 15] == 64'h6666_0F06_0000_0042,
            "R8 next primitive intact", cap[base & 15], 64'h6666_0F06_0000_0042);

        // R9 local queue overflow: pushes 5 and 7 (0-based) meet a full queue.
        base = mon_total;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            loc_valid = 1'b1;
            loc_prim  = 64'hA000_0000_0000_0000 | 64'(i);
        end
        @(negedge clk);
        loc_valid = 1'b0;
        idle(40);
        chk(ovf_flag, "R9 ovf_flag set", 64'(ovf_flag), 64'h1);
        chk(mon_total - base == 6, "R9 whole primitives sent", 64'(mon_total - base), 64'h6);
        for (int k = 0; k < 6; k++) begin
            logic [63:0] e;
            e = 64'hA000_0000_0000_0000 | 64'((k < 5) ? k : 6);
            chk(cap[(base + k) & 15] == e, "R9 surviving order", cap[(base + k) & 15], e);
        end
        idle(5);
        chk(ovf_flag, "R9 ovf_flag sticky", 64'(ovf_flag), 64'h1);

        // R10 reset mid-traffic clears queues, counter and flag.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            loc_valid = 1'b1;
            loc_prim  = 64'hB000_0000_0000_0000 | 64'(i);
        end
        @(negedge clk);
        loc_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!dn_valid, "R10 output stopped", 64'(dn_valid), 64'h0);
        chk(frag_count == 0 && !ovf_flag, "R10 status cleared",
            64'({frag_count, ovf_flag}), 64'h0);
        rst_n = 1'b1;
        base = mon_total;
        idle(20);
        chk(mon_total == base, "R10 queues emptied", 64'(mon_total - base), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule